// File: doc/BRIEF.md
# Per-Core Interrupt Acceptor with End-of-Interrupt

This block sits beside one processor core and collects interrupt messages sent by an external interrupt router. Each message carries an 8-bit vector, a destination ID and a trigger-mode flag. A message is taken only when its destination equals the core's own ID and the block is globally enabled. A taken message sets a request bit for its vector. The block keeps three 256-bit registers: a request register, an in-service register and a register that records the trigger mode of each vector.

The block offers the highest pending vector to the processor over a request/acknowledge handshake. It offers it only when the vector's priority class, which is its upper four bits, is above the class of the highest vector now in service. On acknowledge the vector leaves the request register, enters the in-service register and is returned to the processor. If no vector is eligible at that moment, the block returns the programmable spurious vector and changes no state.

Software uses a 32-bit register port with three registers. The ID register holds the core's ID. The spurious register holds the global enable and the spurious vector. The write-only end-of-interrupt register retires the highest in-service vector. If the retired vector arrived level-triggered, the block sends an end-of-interrupt notice carrying that vector back to the router.

Top module: `irq_acceptor`

## Requirements
- R1: After reset the enable bit (spurious register bit 8) is 0, the spurious vector (bits 7:0) is 0xFF, the ID register reads 0 and irq_req_o is low.
- R2: The spurious register at offset 0xF0 stores write data bits 8:0. It reads back bit 8 as the enable and bits 7:0 as the spurious vector, and all other bits read 0.
- R3: The ID register at offset 0x20 stores write data bits 31:24 as the ID and reads back with bits 23:0 at 0.
- R4: Offsets other than 0x20 and 0xF0 read as 0. This includes the end-of-interrupt offset 0xB0. Writes to unmapped offsets leave the ID and spurious registers unchanged.
- R5: A message is taken only when msg_dest_i equals the ID. A message with any other destination is dropped and raises no request.
- R6: irq_req_o is high when the enable bit is 1, a request is pending, and the upper four bits of the highest pending vector are greater than those of the highest in-service vector (or nothing is in service). While irq_req_o is high, irq_vector_o shows the highest pending vector.
- R7: An acknowledge while irq_req_o is high moves that vector from request to in-service. The vector is no longer offered afterwards.
- R8: An acknowledge while irq_req_o is low returns the spurious vector on irq_vector_o and sets no in-service bit.
- R9: Any write to offset 0xB0 clears the highest-numbered in-service bit, whatever the write data.
- R10: When the retired vector was taken with msg_level_i = 1, eoi_valid_o pulses for one cycle in the cycle after the write and eoi_vector_o carries the vector. An edge-triggered vector raises no pulse.
- R11: While the enable bit is 0, messages are dropped and irq_req_o stays low. Requests already pending are held and are offered again once the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msg_valid_i | input | 1 | Incoming interrupt message strobe |
| msg_vector_i | input | 8 | Vector of the incoming message |
| msg_dest_i | input | 8 | Destination ID of the incoming message |
| msg_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| irq_req_o | output | 1 | Interrupt request to the processor |
| irq_ack_i | input | 1 | Processor acknowledge, one cycle |
| irq_vector_o | output | 8 | Vector returned; sampled in the acknowledge cycle |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| eoi_valid_o | output | 1 | End-of-interrupt notice to the router |
| eoi_vector_o | output | 8 | Vector of the notice |

## Verification
A wrong request or in-service bit shows up at irq_req_o and irq_vector_o. It appears within one cycle of the message or acknowledge that corrupted it, or it appears later as a nesting order that breaks the class rule once end-of-interrupt writes unwind the stack. A lost trigger-mode bit appears only at eoi_valid_o, one cycle after the write that retires that vector. For this reason the sweep takes every vector through a full accept, acknowledge and retire cycle. It checks irq_vector_o at the acknowledge and eoi_valid_o right after the retire.

// File: rtl/irq_acceptor_pkg.sv
package irq_acceptor_pkg;
  localparam int unsigned OFS_ID  = 32'h020;
  localparam int unsigned OFS_EOI = 32'h0B0;
  localparam int unsigned OFS_SVR = 32'h0F0;
  localparam int unsigned CLS_W   = 4;
  localparam logic [7:0]  SPUR_RST = 8'hFF;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |bits_i;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_acceptor_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ID_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [VEC_W-1:0]  spur_vec_o,
  output logic [ID_W-1:0]   id_o,
  output logic              eoi_wr_o
);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
  localparam logic [ADDR_W-1:0] A_SVR = ADDR_W'(OFS_SVR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      spur_vec_o <= VEC_W'(SPUR_RST);
      id_o       <= '0;
    end else if (wr_i) begin
      if (addr_i == A_SVR) begin
        en_o       <= wdata_i[VEC_W];
        spur_vec_o <= wdata_i[VEC_W-1:0];
      end
      if (addr_i == A_ID) id_o <= wdata_i[DATA_W-1 -: ID_W];
    end
  end

  assign eoi_wr_o = wr_i && (addr_i == A_EOI);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_ID) begin
      rdata_o[DATA_W-1 -: ID_W] = id_o;
    end else if (addr_i == A_SVR) begin
      rdata_o[VEC_W]     = en_o;
      rdata_o[VEC_W-1:0] = spur_vec_o;
    end
  end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned NV   = 1 << VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             set_level_i,
  input  logic             take_i,
  input  logic [VEC_W-1:0] take_vec_i,
  input  logic             retire_i,
  input  logic [VEC_W-1:0] retire_vec_i,
  output logic [NV-1:0]    irr_o,
  output logic [NV-1:0]    isr_o,
  output logic             bcast_o,
  output logic [VEC_W-1:0] bcast_vec_o
);
  logic [NV-1:0] tmr, irr_n, isr_n, tmr_n;

  always_comb begin
    irr_n = irr_o;
    isr_n = isr_o;
    tmr_n = tmr;
    if (take_i) begin
      irr_n[take_vec_i] = 1'b0;
      isr_n[take_vec_i] = 1'b1;
    end
    if (retire_i) isr_n[retire_vec_i] = 1'b0;
    // a new message re-pends even a vector taken in the same cycle
    if (set_i) begin
      irr_n[set_vec_i] = 1'b1;
      tmr_n[set_vec_i] = set_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_o       <= '0;
      isr_o       <= '0;
      tmr         <= '0;
      bcast_o     <= 1'b0;
      bcast_vec_o <= '0;
    end else begin
      irr_o       <= irr_n;
      isr_o       <= isr_n;
      tmr         <= tmr_n;
      bcast_o     <= retire_i && tmr[retire_vec_i];
      bcast_vec_o <= retire_vec_i;
    end
  end
endmodule

// File: rtl/irq_acceptor.sv
module irq_acceptor
  import irq_acceptor_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [VEC_W-1:0]  msg_vector_i,
  input  logic [ID_W-1:0]   msg_dest_i,
  input  logic              msg_level_i,
  output logic              irq_req_o,
  input  logic              irq_ack_i,
  output logic [VEC_W-1:0]  irq_vector_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              eoi_valid_o,
  output logic [VEC_W-1:0]  eoi_vector_o
);
  localparam int unsigned NV = 1 << VEC_W;

  logic             en, eoi_wr, irr_any, isr_any, accept, take, retire;
  logic [VEC_W-1:0] spur_vec, irr_top, isr_top;
  logic [ID_W-1:0]  id;
  logic [NV-1:0]    irr, isr;

  irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .ID_W(ID_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en), .spur_vec_o(spur_vec), .id_o(id), .eoi_wr_o(eoi_wr)
  );

  irq_prio_enc #(.N(NV), .W(VEC_W)) u_irr_enc (.bits_i(irr), .any_o(irr_any), .idx_o(irr_top));
  irq_prio_enc #(.N(NV), .W(VEC_W)) u_isr_enc (.bits_i(isr), .any_o(isr_any), .idx_o(isr_top));

  assign accept    = msg_valid_i && en && (msg_dest_i == id);
  assign irq_req_o = en && irr_any &&
                     (!isr_any || (irr_top[VEC_W-1 -: CLS_W] > isr_top[VEC_W-1 -: CLS_W]));
  assign irq_vector_o = irq_req_o ? irr_top : spur_vec;
  assign take      = irq_ack_i && irq_req_o;
  assign retire    = eoi_wr && isr_any;

  irq_vec_state #(.VEC_W(VEC_W)) u_state (
    .clk_i, .rst_ni,
    .set_i(accept), .set_vec_i(msg_vector_i), .set_level_i(msg_level_i),
    .take_i(take), .take_vec_i(irr_top),
    .retire_i(retire), .retire_vec_i(isr_top),
    .irr_o(irr), .isr_o(isr),
    .bcast_o(eoi_valid_o), .bcast_vec_o(eoi_vector_o)
  );
endmodule

// File: rtl/irq_acceptor_chk.sv
module irq_acceptor_chk
  import irq_acceptor_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned NV    = 1 << VEC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic [VEC_W-1:0]  spur_vec,
  input logic [ID_W-1:0]   id,
  input logic [NV-1:0]     irr,
  input logic [NV-1:0]     isr,
  input logic              isr_any,
  input logic [VEC_W-1:0]  isr_top,
  input logic              irq_req_o,
  input logic              irq_ack_i,
  input logic [VEC_W-1:0]  irq_vector_o,
  input logic              msg_valid_i,
  input logic [VEC_W-1:0]  msg_vector_i,
  input logic [ID_W-1:0]   msg_dest_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              eoi_valid_o
);
  p_req_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_req_o);

  p_ack_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_req_o) |-> (irq_vector_o == spur_vec));

  p_req_class_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && isr_any) |->
      (irq_vector_o[VEC_W-1 -: CLS_W] > isr_top[VEC_W-1 -: CLS_W]));

  p_ack_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> isr[$past(irq_vector_o)]);

  p_dest_filter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && (msg_dest_i != id) && !irr[msg_vector_i]) |=> !irr[$past(msg_vector_i)]);

  p_bcast_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> $past(reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EOI))));
endmodule

bind irq_acceptor irq_acceptor_chk #(.VEC_W(VEC_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .en, .spur_vec, .id, .irr, .isr, .isr_any, .isr_top,
  .irq_req_o, .irq_ack_i, .irq_vector_o, .msg_valid_i, .msg_vector_i, .msg_dest_i,
  .reg_wr_i, .reg_addr_i, .eoi_valid_o
);

// File: tb/tb_irq_acceptor.sv
`timescale 1ns/1ps
module tb_irq_acceptor;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        msg_valid = 0, msg_level = 0, ack = 0, wr = 0;
  logic [7:0]  msg_vec = 0, msg_dest = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic        req, eoi_v;
  logic [7:0]  vec_o, eoi_vec;
  logic [31:0] rdata;
  int n_chk = 0, n_fail = 0;
  logic        last_eoi_v;
  logic [7:0]  last_eoi_vec;

  always #5 clk = ~clk;

  irq_acceptor dut (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_vector_i(msg_vec), .msg_dest_i(msg_dest), .msg_level_i(msg_level),
    .irq_req_o(req), .irq_ack_i(ack), .irq_vector_o(vec_o),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eoi_valid_o(eoi_v), .eoi_vector_o(eoi_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); last_eoi_v = eoi_v; last_eoi_vec = eoi_vec; wr = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic send(input logic [7:0] v, input logic [7:0] dst, input logic lvl);
    @(negedge clk); msg_vec = v; msg_dest = dst; msg_level = lvl; msg_valid = 1;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1; #1 v = vec_o;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd_reg(12'h0F0, d); check("R1 svr reset", d, 32'h0FF);
    rd_reg(12'h020, d); check("R1 id reset", d, 0);
    check("R1 req reset", req, 0);
    // R11: disabled drops messages
    send(8'h40, 8'h00, 0);
    wr_reg(12'h0F0, 32'hFFFF_FF00 | 32'h1FF);
    rd_reg(12'h0F0, d); check("R2 svr readback", d, 32'h1FF);
    @(negedge clk); check("R11 dropped while disabled", req, 0);
    // R3 / R4
    wr_reg(12'h020, 32'h5A12_3456);
    rd_reg(12'h020, d); check("R3 id readback", d, 32'h5A00_0000);
    wr_reg(12'h030, 32'hFFFF_FFFF);
    rd_reg(12'h030, d); check("R4 unmapped read", d, 0);
    rd_reg(12'h0B0, d); check("R4 eoi reads zero", d, 0);
    rd_reg(12'h020, d); check("R4 id unchanged", d, 32'h5A00_0000);
    rd_reg(12'h0F0, d); check("R4 svr unchanged", d, 32'h1FF);
    // R5
    send(8'h40, 8'h00, 0);
    @(negedge clk); check("R5 wrong dest dropped", req, 0);
    // sweep every vector: R6 R7 R9 R10
    for (int i = 0; i < 256; i++) begin
      send(i[7:0], 8'h5A, i[0]);
      @(negedge clk);
      check("R6 req sweep", req, 1);
      check("R6 vector sweep", vec_o, i);
      do_ack(v);
      check("R7 ack vector", v, i);
      check("R7 req cleared", req, 0);
      wr_reg(12'h0B0, 32'h0);
      check("R10 eoi pulse", last_eoi_v, i[0]);
      if (i[0]) check("R10 eoi vector", last_eoi_vec, i);
    end
    // nesting by class
    send(8'h35, 8'h5A, 1);
    do_ack(v); check("R7 take 0x35", v, 8'h35);
    send(8'h31, 8'h5A, 0);
    @(negedge clk); check("R6 same class blocked", req, 0);
    send(8'h52, 8'h5A, 0);
    @(negedge clk); check("R6 higher class", req, 1); check("R6 higher vector", vec_o, 8'h52);
    do_ack(v); check("R7 take 0x52", v, 8'h52);
    wr_reg(12'h0B0, 32'hDEAD_BEEF);
    check("R10 edge no pulse", last_eoi_v, 0);
    @(negedge clk); check("R9 0x35 still in service", req, 0);
    wr_reg(12'h0B0, 32'h0);
    check("R10 level pulse", last_eoi_v, 1); check("R10 level vector", last_eoi_vec, 8'h35);
    @(negedge clk); check("R9 0x31 offered", req, 1); check("R9 vector 0x31", vec_o, 8'h31);
    do_ack(v); wr_reg(12'h0B0, 32'h0);
    // R8: spurious acknowledge
    wr_reg(12'h0F0, 32'h13F);
    do_ack(v); check("R8 spurious vector", v, 8'h3F);
    send(8'h20, 8'h5A, 0);
    @(negedge clk); check("R8 no in-service set", req, 1);
    // R11: pending held across disable
    wr_reg(12'h0F0, 32'h03F);
    @(negedge clk); check("R11 req off when disabled", req, 0);
    wr_reg(12'h0F0, 32'h13F);
    @(negedge clk); check("R11 req back", req, 1); check("R11 held vector", vec_o, 8'h20);
    do_ack(v); wr_reg(12'h0B0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule